// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block maps the four shared PCI interrupt lines (INTA, INTB, INTC, INTD) onto numbered system interrupt requests. Firmware programs the mapping through byte writes to a window of eight configuration offsets starting at 0x88. Each written byte carries two 4-bit route fields. Whether the offset is odd or even decides which pair of lines the two fields program.

A route field selects one of seven fixed IRQ numbers through a 1-based 3-bit index. A field whose low three bits are zero turns the line off. For each line the block reports the selected IRQ number and a valid flag. It also drives a registered 16-bit ISA request vector: each active-low PCI interrupt that is asserted on an enabled line raises the bit of its IRQ. Lines that share an IRQ are ORed together. Every byte written in the window can be read back.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset all four lines are disabled (valid 0, number 0), the request vector is 0 and every offset in 0x88..0x8F reads 0.
- R2: A write to an odd offset in 0x88..0x8F programs INTA from bits 7:4 and INTB from bits 3:0, and leaves INTC and INTD unchanged.
- R3: A write to an even offset in 0x88..0x8F programs INTC from bits 7:4 and INTD from bits 3:0, and leaves INTA and INTB unchanged.
- R4: A route field of 0 disables its line: valid 0, number 0, and no request bit is raised.
- R5: For a field with nonzero low three bits s (1..7), the line number is 5, 9, 10, 11, 12, 14 or 15 respectively for s = 1..7, and bit 3 of the field has no effect.
- R6: A route field of 8 (low three bits zero) disables the line, like R4.
- R7: Reading any offset in 0x88..0x8F returns the last byte written there. Reads outside the window return 0, and writes outside the window change neither the routing nor the stored bytes.
- R8: The most recent write decides a line's routing, whichever offset of matching parity it used.
- R9: The request bit of an IRQ is 1 exactly when some enabled line routed to it has its input low. Line i uses pci_int_n[i], with A=0, B=1, C=2, D=3.
- R10: Lines routed to the same IRQ are ORed onto that one request bit.
- R11: The line number and valid flag change at the clock edge that takes the write. The request vector reflects routing and inputs one clock edge later, and does not change before that edge.
- R12: cfg_rdata shows the byte at cfg_addr as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset for write and read |
| cfg_wdata | input | 8 | Byte to write |
| cfg_rdata | output | 8 | Registered readback of the byte at cfg_addr |
| pci_int_n | input | 4 | Active-low PCI interrupts, bit 0 = INTA ... bit 3 = INTD |
| line_irq_num | output | 16 | Per-line IRQ number, 4 bits per line, INTA in bits 3:0 |
| line_irq_vld | output | 4 | Per-line enable flag, bit 0 = INTA |
| isa_irq | output | 16 | Registered ISA IRQ request vector, bit n = IRQ n |

## Verification
Suppose a route register takes the wrong field, or the odd/even swap goes the wrong way. Then line_irq_num and line_irq_vld show the mismatch right after the edge that took the write. The wrong request bit appears on isa_irq one edge later. A wrong table index shows up as a number outside the seven legal values. A stored byte that is stale or corrupted shows up only when the offset is read back, one edge after the address is presented. A lost OR between lines that share an IRQ shows up only when one line drops its input while the other keeps its input asserted.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int LINE_CNT = 4;
  localparam int NUM_W    = 4;
  localparam int SEL_W    = 3;

  typedef enum logic [1:0] {
    LN_A = 2'd0,
    LN_B = 2'd1,
    LN_C = 2'd2,
    LN_D = 2'd3
  } line_e;

  // 1-based selector to IRQ number; selector 0 yields 0 (disabled)
  function automatic logic [NUM_W-1:0] sel_to_irq(input logic [SEL_W-1:0] sel);
    logic [NUM_W-1:0] r;
    case (sel)
      3'd1:    r = 4'd5;
      3'd2:    r = 4'd9;
      3'd3:    r = 4'd10;
      3'd4:    r = 4'd11;
      3'd5:    r = 4'd12;
      3'd6:    r = 4'd14;
      3'd7:    r = 4'd15;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  function automatic logic irq_is_legal(input logic [NUM_W-1:0] n);
    return (n == 4'd5) || (n == 4'd9) || (n == 4'd10) || (n == 4'd11) ||
           (n == 4'd12) || (n == 4'd14) || (n == 4'd15);
  endfunction

endpackage

// File: rtl/pirq_field_decode.sv
module pirq_field_decode
  import pirq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] field,
  output logic [NUM_W-1:0]   irq_num,
  output logic               irq_vld
);

  logic [SEL_W-1:0] sel;

  always_comb begin
    sel     = field[SEL_W-1:0];
    irq_vld = (sel != '0);
    irq_num = irq_vld ? sel_to_irq(sel) : '0;
  end

endmodule

// File: rtl/pirq_cfg_store.sv
module pirq_cfg_store #(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h88,
  parameter int                SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [DATA_W-1:0] mem [SLOTS];
  logic [ADDR_W-1:0] offs;
  logic              in_rng;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    offs   = addr - BASE;
    in_rng = (addr >= BASE) && (offs < ADDR_W'(SLOTS));
    idx    = offs[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SLOTS; k++) mem[k] <= '0;
    end else if (we && in_rng) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (in_rng) rdata <= mem[idx];
    else             rdata <= '0;
  end

  a_r7_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !in_rng |=> (rdata == '0));

  a_r12_read_follows_store: assert property (@(posedge clk) disable iff (rst)
    (in_rng && !we) |=> (rdata == $past(mem[idx])));

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h88,
  parameter int                SLOTS  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [LINE_CNT*NUM_W-1:0] num_q,
  output logic [LINE_CNT-1:0]       vld_q
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] offs;
  logic              in_rng;
  logic              odd_slot;
  logic [NUM_W-1:0]  hi_num, lo_num;
  logic              hi_vld, lo_vld;

  always_comb begin
    offs     = addr - BASE;
    in_rng   = (addr >= BASE) && (offs < ADDR_W'(SLOTS));
    odd_slot = addr[0];
  end

  pirq_field_decode #(.FIELD_W(HALF_W)) u_dec_hi (
    .field   (wdata[DATA_W-1:HALF_W]),
    .irq_num (hi_num),
    .irq_vld (hi_vld)
  );

  pirq_field_decode #(.FIELD_W(HALF_W)) u_dec_lo (
    .field   (wdata[HALF_W-1:0]),
    .irq_num (lo_num),
    .irq_vld (lo_vld)
  );

  // Lines 0,1 (A,B) are owned by odd offsets; lines 2,3 (C,D) by even.
  // Within a pair the lower-numbered line takes the high field.
  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    localparam bit OWN_ODD = (i < 2);
    localparam bit USE_HI  = ((i % 2) == 0);
    logic hit;
    assign hit = we && in_rng && (odd_slot == OWN_ODD);

    always_ff @(posedge clk) begin
      if (rst) begin
        num_q[i*NUM_W +: NUM_W] <= '0;
        vld_q[i]                <= 1'b0;
      end else if (hit) begin
        num_q[i*NUM_W +: NUM_W] <= USE_HI ? hi_num : lo_num;
        vld_q[i]                <= USE_HI ? hi_vld : lo_vld;
      end
    end

    a_r5_number_legal: assert property (@(posedge clk) disable iff (rst)
      vld_q[i] |-> irq_is_legal(num_q[i*NUM_W +: NUM_W]));

    a_r4_off_means_zero: assert property (@(posedge clk) disable iff (rst)
      !vld_q[i] |-> (num_q[i*NUM_W +: NUM_W] == '0));
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld_q == '0));

  a_r2_odd_keeps_cd: assert property (@(posedge clk) disable iff (rst)
    (we && in_rng && odd_slot) |=>
      ($stable(vld_q[3:2]) && $stable(num_q[4*NUM_W-1:2*NUM_W])));

  a_r3_even_keeps_ab: assert property (@(posedge clk) disable iff (rst)
    (we && in_rng && !odd_slot) |=>
      ($stable(vld_q[1:0]) && $stable(num_q[2*NUM_W-1:0])));

  a_r7_outside_no_route: assert property (@(posedge clk) disable iff (rst)
    !in_rng |=> ($stable(vld_q) && $stable(num_q)));

endmodule

// File: rtl/pirq_req_merge.sv
module pirq_req_merge
  import pirq_pkg::*;
#(
  parameter int IRQS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LINE_CNT-1:0]       int_n,
  input  logic [LINE_CNT*NUM_W-1:0] num,
  input  logic [LINE_CNT-1:0]       vld,
  output logic [IRQS-1:0]           irq_q
);

  logic [IRQS-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int l = 0; l < LINE_CNT; l++) begin
      if (vld[l] && !int_n[l]) begin
        for (int q = 0; q < IRQS; q++) begin
          if (num[l*NUM_W +: NUM_W] == NUM_W'(q)) irq_d[q] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (&int_n) |=> (irq_q == '0));

  a_r10_bits_bounded: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_q) <= LINE_CNT);

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (vld == '0) |=> (irq_q == '0));

endmodule

// File: rtl/pci_irq_steer.sv
module pci_irq_steer
  import pirq_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h88,
  parameter int                SLOTS  = 8,
  parameter int                IRQS   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output logic [DATA_W-1:0]         cfg_rdata,
  input  logic [LINE_CNT-1:0]       pci_int_n,
  output logic [LINE_CNT*NUM_W-1:0] line_irq_num,
  output logic [LINE_CNT-1:0]       line_irq_vld,
  output logic [IRQS-1:0]           isa_irq
);

  pirq_cfg_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .SLOTS(SLOTS)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata)
  );

  pirq_route_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .SLOTS(SLOTS)
  ) u_route (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .num_q (line_irq_num),
    .vld_q (line_irq_vld)
  );

  pirq_req_merge #(.IRQS(IRQS)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .int_n (pci_int_n),
    .num   (line_irq_num),
    .vld   (line_irq_vld),
    .irq_q (isa_irq)
  );

  a_r11_vec_lags_route: assert property (@(posedge clk) disable iff (rst)
    ($past(line_irq_vld) == '0) |-> (isa_irq == '0));

endmodule

// File: tb/pci_irq_steer_tb.sv
module pci_irq_steer_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pci_int_n;
  logic [15:0] line_irq_num;
  logic [3:0]  line_irq_vld;
  logic [15:0] isa_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pci_irq_steer u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int_n(pci_int_n),
    .line_irq_num(line_irq_num), .line_irq_vld(line_irq_vld), .isa_irq(isa_irq)
  );

  // {addr, data, int_n, exp isa_irq, exp vld, exp num}
  localparam logic [55:0] VEC [8] = '{
    {8'h89, 8'h21, 4'hC, 16'h0220, 4'h3, 16'h0059},
    {8'h8A, 8'h73, 4'h0, 16'h8620, 4'hF, 16'hAF59},
    {8'h8F, 8'h0E, 4'h0, 16'hC400, 4'hE, 16'hAFE0},
    {8'h8C, 8'h84, 4'h0, 16'h4800, 4'hA, 16'hB0E0},
    {8'h88, 8'h55, 4'h7, 16'h1000, 4'hE, 16'hCCE0},
    {8'h88, 8'h55, 4'hB, 16'h1000, 4'hE, 16'hCCE0},
    {8'h8D, 8'hD7, 4'hE, 16'h1000, 4'hF, 16'hCCFC},
    {8'h40, 8'h12, 4'hD, 16'h8000, 4'hF, 16'hCCFC}
  };

  function automatic logic [3:0] exp_irq(input logic [3:0] f);
    case (f[2:0])
      3'd1: return 4'd5;   3'd2: return 4'd9;   3'd3: return 4'd10;
      3'd4: return 4'd11;  3'd5: return 4'd12;  3'd6: return 4'd14;
      3'd7: return 4'd15;  default: return 4'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    @(posedge clk);
    @(negedge clk);
    check(req, {8'h0, cfg_rdata}, {8'h0, exp});
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = 8'h0; cfg_wdata = 8'h0; pci_int_n = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pci_int_n = 4'h0;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 vld", {12'h0, line_irq_vld}, 16'h0);
    check("R1 num", line_irq_num, 16'h0);
    check("R1 irq", isa_irq, 16'h0);
    rd_check(8'h8B, 8'h00, "R1 readback");

    // Table walk: R2 R3 R4 R6 R8 R9 R10 R7
    for (int i = 0; i < 8; i++) begin
      logic [55:0] v;
      v = VEC[i];
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = v[55:48]; cfg_wdata = v[47:40];
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0; pci_int_n = v[39:36];
      check($sformatf("R2/R3 vld row%0d", i), {12'h0, line_irq_vld}, {12'h0, v[19:16]});
      check($sformatf("R8 num row%0d", i), line_irq_num, v[15:0]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R9 R10 irq row%0d", i), isa_irq, v[35:20]);
    end

    // R7 readback of every slot and out of range
    rd_check(8'h88, 8'h55, "R7 88");
    rd_check(8'h89, 8'h21, "R7 89");
    rd_check(8'h8A, 8'h73, "R7 8A");
    rd_check(8'h8B, 8'h00, "R7 8B");
    rd_check(8'h8C, 8'h84, "R7 8C");
    rd_check(8'h8D, 8'hD7, "R7 8D");
    rd_check(8'h8E, 8'h00, "R7 8E");
    rd_check(8'h8F, 8'h0E, "R7 8F");
    rd_check(8'h40, 8'h00, "R7 outside");

    // R12: readback lags address by one edge
    @(negedge clk);
    cfg_addr = 8'h8C;
    @(posedge clk);
    @(negedge clk);
    cfg_addr = 8'h8D;
    check("R12 lag", {8'h0, cfg_rdata}, 16'h0084);

    // R11: vector does not move before the edge
    @(negedge clk);
    pci_int_n = 4'hF;
    @(posedge clk);
    @(negedge clk);
    check("R11 idle", isa_irq, 16'h0);
    pci_int_n = 4'hD;
    #1;
    check("R11 before edge", isa_irq, 16'h0);
    @(posedge clk);
    @(negedge clk);
    check("R11 after edge", isa_irq, 16'h8000);

    // R5 R6: every field value on INTA via odd offset
    pci_int_n = 4'hE;
    for (int f = 0; f < 16; f++) begin
      logic [3:0] e;
      e = exp_irq(4'(f));
      wr(8'h8B, {4'(f), 4'h0});
      check($sformatf("R5 R6 num f=%0d", f), {12'h0, line_irq_num[3:0]}, {12'h0, e});
      check($sformatf("R5 R6 vld f=%0d", f), {15'h0, line_irq_vld[0]}, {15'h0, (e != 0)});
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R4 R9 irq f=%0d", f), isa_irq, (e != 0) ? (16'h1 << e) : 16'h0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule